// File: doc/BRIEF.md
# Virtual memory map preset engine

After reset, a page map has to be put into a known state before any translated reference can be made. This block does that as a sequencer. It reads a storage configuration word and works out which memory modules are fitted and how many pages each one holds. It then writes map entries that send consecutive virtual pages, starting at page 0, to the real pages of the fitted modules, in ascending order. The real-page ranges of absent modules are skipped.

Once real storage is used up, every virtual page left in the map is written with a vacant entry. A vacant entry is write-protected and dirty, and its real page is all ones. Each entry goes out on a single-cycle write port, guarded by the map buffer's busy flag.

The block has no way to report absent storage other than halting. If the configuration word shows no module at all, it stops in a sticky error state and writes nothing.

Top module: `mmap_preset`

## Requirements
- R1: While reset is held, and after it until start_i, the block is idle: map_we_o, done_o and err_o are 0.
- R2: On start_i in idle, the block inverts cfg_i to get a presence mask. Bits [7:4] of the mask are the four module-present flags, scanned from bit 7 down. Bits [3:2] of the mask are a size code S, and each module holds 256 << 2S pages.
- R3: A present module maps consecutive virtual pages to consecutive real pages. Virtual pages start at 0, and the real pages start at that module's real base. These entries carry write-protect 0 and dirty 0.
- R4: An absent module writes no entry, but it advances the real base by one module's page count. The real base starts at 0.
- R5: After real storage runs out, every remaining virtual page up to MAP_PAGES-1 is written with write-protect 1, dirty 1 and real page all ones.
- R6: If the last virtual page (MAP_PAGES-1) is written while a module is being mapped, mapping stops and no vacant entries follow.
- R7: Each write carries the entry's base address, which is the virtual page shifted left by PAGE_BITS. Its low 16 bits appear on map_va_lo_o and the next 16 bits on map_va_hi_o.
- R8: map_we_o is high for exactly one cycle per entry. It is raised only when map_busy_i was low at the previous clock edge. Every virtual page of the map is written exactly once per run.
- R9: done_o is a single-cycle pulse after the last map write of a run. The block then returns to idle.
- R10: If the presence flags are all zero, err_o goes high in the cycle after start_i and stays high until reset. No entry is written and done_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a preset run (sampled in idle) |
| cfg_i | input | 16 | Storage configuration word, active low |
| map_busy_i | input | 1 | Map buffer busy flag |
| map_we_o | output | 1 | Map entry write strobe |
| map_va_lo_o | output | 16 | Low half of the entry's base address |
| map_va_hi_o | output | 16 | High half of the entry's base address |
| map_rpage_o | output | 16 | Real page of the entry |
| map_wp_o | output | 1 | Write-protect bit of the entry |
| map_dirty_o | output | 1 | Dirty bit of the entry |
| done_o | output | 1 | Run-complete pulse |
| err_o | output | 1 | No-storage error, sticky |

## Verification
The results do not arrive on a fixed schedule.

- **Error flag:** err_o is due one clock edge after the start edge, and the bench samples it at the next falling edge.
- **Map writes:** a write appears on the falling edge after the edge on which the write gate saw map_busy_i low. The bench therefore records the busy value at every rising edge and checks each strobe against that record.
- **Map contents and done:** the map contents and done_o depend on how long busy stalls last. The bench logs every strobe into a map model, waits for done_o, and only then compares the whole map, the per-entry write count and the single done pulse against a map it computes from the presence mask.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_MAP_NEXT, S_MAP_REQ, S_VAC_NEXT, S_VAC_REQ, S_DONE, S_ERR
  } seq_state_e;

  typedef enum logic [1:0] {G_IDLE, G_PRE, G_WR, G_POST} gate_state_e;

  localparam int unsigned NUM_MODULES = 4;
endpackage

// File: rtl/mmap_cfg_decode.sv
module mmap_cfg_decode #(
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned PG_W       = 16,
  parameter int unsigned BASE_PAGES = 256
) (
  input  logic [CFG_W-1:0]                  cfg_i,
  output logic [mmap_pkg::NUM_MODULES-1:0]  present_o,
  output logic [PG_W-1:0]                   ppm_o
);
  logic [CFG_W-1:0] mask;
  logic [1:0]       size_code;

  always_comb begin
    mask      = ~cfg_i;
    present_o = mask[7:4];
    size_code = mask[3:2];
    ppm_o     = PG_W'(BASE_PAGES) << {size_code, 1'b0};
  end
endmodule

// File: rtl/mmap_write_gate.sv
module mmap_write_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  output logic we_o,
  output logic ack_o
);
  import mmap_pkg::*;

  gate_state_e st;

  // wait for buffer idle before the write and again after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st <= G_IDLE;
    else begin
      unique case (st)
        G_IDLE:  if (req_i)   st <= G_PRE;
        G_PRE:   if (!busy_i) st <= G_WR;
        G_WR:                 st <= G_POST;
        G_POST:  if (!busy_i) st <= G_IDLE;
        default:              st <= G_IDLE;
      endcase
    end
  end

  assign we_o  = (st == G_WR);
  assign ack_o = (st == G_POST) && !busy_i;

  // R8
  we_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(!busy_i));
  // R8
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
endmodule

// File: rtl/mmap_preset.sv
module mmap_preset #(
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned PG_W       = 16,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_BITS  = 10,
  parameter int unsigned BASE_PAGES = 256,
  parameter int unsigned MAP_PAGES  = 16384
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              map_busy_i,
  output logic              map_we_o,
  output logic [ADDR_W-1:0] map_va_lo_o,
  output logic [ADDR_W-1:0] map_va_hi_o,
  output logic [PG_W-1:0]   map_rpage_o,
  output logic              map_wp_o,
  output logic              map_dirty_o,
  output logic              done_o,
  output logic              err_o
);
  import mmap_pkg::*;

  localparam int unsigned VA_W = 2 * ADDR_W;
  localparam logic [PG_W-1:0] LAST_VP = PG_W'(MAP_PAGES - 1);

  seq_state_e                state;
  logic [NUM_MODULES-1:0]    present, mod_left;
  logic [PG_W-1:0]           ppm_dec, ppm, vpage, rpage, cnt;
  logic                      vacant, req, ack, vp_last;
  logic [VA_W-1:0]           va;

  mmap_cfg_decode #(.CFG_W(CFG_W), .PG_W(PG_W), .BASE_PAGES(BASE_PAGES)) i_dec (
    .cfg_i(cfg_i), .present_o(present), .ppm_o(ppm_dec)
  );

  mmap_write_gate i_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .busy_i(map_busy_i),
    .we_o(map_we_o), .ack_o(ack)
  );

  assign vp_last = (vpage == LAST_VP);
  assign req     = (state == S_MAP_REQ) || (state == S_VAC_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      mod_left <= '0;
      ppm      <= '0;
      vpage    <= '1;
      rpage    <= '1;
      cnt      <= '0;
      vacant   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          if (present == '0) state <= S_ERR;
          else begin
            mod_left <= present;
            ppm      <= ppm_dec;
            vpage    <= '1;      // counters pre-increment from -1
            rpage    <= '1;
            vacant   <= 1'b0;
            state    <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (mod_left == '0) state <= S_VAC_NEXT;
          else begin
            if (mod_left[NUM_MODULES-1]) begin
              cnt   <= ppm;
              state <= S_MAP_NEXT;
            end else rpage <= rpage + ppm;  // hole in real memory
            mod_left <= mod_left << 1;
          end
        end
        S_MAP_NEXT: begin
          if (vp_last)         state <= S_DONE;
          else if (cnt == '0)  state <= S_SCAN;
          else begin
            vpage <= vpage + 1'b1;
            rpage <= rpage + 1'b1;
            cnt   <= cnt - 1'b1;
            state <= S_MAP_REQ;
          end
        end
        S_MAP_REQ: if (ack) state <= S_MAP_NEXT;
        S_VAC_NEXT: begin
          if (vp_last) state <= S_DONE;
          else begin
            vpage  <= vpage + 1'b1;
            vacant <= 1'b1;
            state  <= S_VAC_REQ;
          end
        end
        S_VAC_REQ: if (ack) state <= S_VAC_NEXT;
        S_DONE:    state <= S_IDLE;
        S_ERR:     state <= S_ERR;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign va          = VA_W'(vpage) << PAGE_BITS;
  assign map_va_lo_o = va[ADDR_W-1:0];
  assign map_va_hi_o = va[VA_W-1:ADDR_W];
  assign map_rpage_o = vacant ? '1 : rpage;
  assign map_wp_o    = vacant;
  assign map_dirty_o = vacant;
  assign done_o      = (state == S_DONE);
  assign err_o       = (state == S_ERR);

  // R6
  vpage_in_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_we_o |-> (vpage <= LAST_VP));
  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !ack) |=> (req && $stable(vpage) && $stable(map_rpage_o)));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !map_we_o));
  // R10
  err_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IDLE && start_i && present == '0) |=> err_o);
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (err_o && !map_we_o && !done_o));
endmodule

// File: tb/test_mmap_preset.sv
module test_mmap_preset;
  localparam int MAP = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg = 16'hFFFF;
  logic        busy = 1'b0;
  logic        we, wp, dirty, done, err;
  logic [15:0] va_lo, va_hi, rpage;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  mmap_preset #(.MAP_PAGES(MAP)) i_mmap_preset (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_i(cfg), .map_busy_i(busy),
    .map_we_o(we), .map_va_lo_o(va_lo), .map_va_hi_o(va_hi), .map_rpage_o(rpage),
    .map_wp_o(wp), .map_dirty_o(dirty), .done_o(done), .err_o(err)
  );

  // map model and monitor
  int  m_rp[MAP];
  bit  m_vac[MAP];
  int  m_cnt[MAP];
  int  e_rp[MAP];
  bit  e_vac[MAP];
  int  addr_bad, busy_bad, flag_bad, done_cnt, write_cnt;
  int  busy_mode, stall, lfsr = 7;
  bit  bsy_edge;

  always @(posedge clk) bsy_edge <= busy;

  always @(negedge clk) begin
    if (we) begin
      int v;
      write_cnt++;
      if (bsy_edge) busy_bad++;
      if (done_cnt != 0) flag_bad++;
      v = int'({va_hi, va_lo} >> 10);
      if (va_lo[9:0] != 0 || v >= MAP) addr_bad++;
      else begin
        m_rp[v]  = int'(rpage);
        m_vac[v] = wp;
        if (wp != dirty) flag_bad++;
        m_cnt[v]++;
      end
    end
    if (done) done_cnt++;
    lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
    if (busy_mode != 0 && we) stall = 1 + (lfsr >> 8) % 3;
    else if (busy_mode != 0 && stall == 0 && ((lfsr >> 4) % 7) == 0) stall = 1;
    if (stall > 0) begin busy = 1'b1; stall--; end
    else busy = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_expect(input logic [15:0] mask);
    int ppm, base, v;
    ppm  = 256 << (2 * int'(mask[3:2]));
    base = 0;
    v    = 0;
    for (int m = 7; m >= 4; m--) begin
      if (mask[m])
        for (int i = 0; i < ppm; i++)
          if (v < MAP) begin e_rp[v] = base + i; e_vac[v] = 0; v++; end
      base += ppm;
    end
    for (int k = v; k < MAP; k++) begin e_rp[k] = 16'hFFFF; e_vac[k] = 1; end
  endtask

  task automatic run_map(input logic [15:0] mask, input int bmode, input string tag);
    int bad_map, bad_cnt, guard, n_vac;
    for (int k = 0; k < MAP; k++) begin m_rp[k] = -1; m_vac[k] = 0; m_cnt[k] = 0; end
    addr_bad = 0; busy_bad = 0; flag_bad = 0; done_cnt = 0; write_cnt = 0;
    build_expect(mask);
    busy_mode = bmode;
    @(negedge clk); cfg = ~mask; start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 60000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    bad_map = 0; bad_cnt = 0; n_vac = 0;
    for (int k = 0; k < MAP; k++) begin
      if (m_rp[k] != e_rp[k] || m_vac[k] != e_vac[k]) bad_map++;
      if (m_cnt[k] != 1) bad_cnt++;
      if (m_vac[k]) n_vac++;
    end
    chk(bad_map == 0, tag, "map entries wrong (R3 R4 R5)", bad_map, 0);
    chk(bad_cnt == 0, "R8", {tag, " entries not written exactly once"}, bad_cnt, 0);
    chk(busy_bad == 0, "R8", {tag, " writes while busy"}, busy_bad, 0);
    chk(addr_bad == 0, "R7", {tag, " bad base address"}, addr_bad, 0);
    chk(flag_bad == 0, "R5", {tag, " dirty/wp mismatch or write after done"}, flag_bad, 0);
    chk(done_cnt == 1, "R9", {tag, " done pulses"}, done_cnt, 1);
    chk(write_cnt == MAP, "R8", {tag, " write count"}, write_cnt, MAP);
    chk(err == 1'b0, "R10", {tag, " err on good config"}, int'(err), 0);
    busy_mode = 0;
  endtask

  // R1
  task automatic t_reset;
    chk(we == 0 && done == 0 && err == 0, "R1", "outputs idle in reset",
        int'({we, done, err}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(we == 0 && done == 0 && err == 0, "R1", "outputs idle after reset",
        int'({we, done, err}), 0);
  endtask

  // R3 R4 R5: modules 1010 scan order, size code 0
  task automatic t_holes;
    run_map(16'h00A0, 0, "R4 holes");
  endtask

  // R6 R2: all present, size code 1, map fills before storage runs out
  task automatic t_full;
    int n_vac;
    run_map(16'h00F4, 1, "R6 full");
    n_vac = 0;
    for (int k = 0; k < MAP; k++) if (m_vac[k]) n_vac++;
    chk(n_vac == 0, "R6", "vacant entries after full map", n_vac, 0);
    chk(m_rp[MAP-1] == MAP - 1, "R6", "last entry real page", m_rp[MAP-1], MAP - 1);
  endtask

  // R4: only the last scanned module present
  task automatic t_last_only;
    run_map(16'h0010, 1, "R4 last");
    chk(m_rp[0] == 768, "R4", "first real page after three holes", m_rp[0], 768);
  endtask

  // R2: size code 2 -> 4096 pages per module
  task automatic t_size2;
    run_map(16'h0048, 0, "R2 size2");
    chk(m_rp[0] == 4096, "R2", "base after one absent 4096-page module", m_rp[0], 4096);
  endtask

  // R10 then R1
  task automatic t_error;
    int w0, d0;
    w0 = write_cnt; d0 = done_cnt;
    @(negedge clk); cfg = ~16'h000C; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err == 1'b1, "R10", "err one cycle after start", int'(err), 1);
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R10", "err sticky", int'(err), 1);
    chk(write_cnt == w0 && done_cnt == d0, "R10", "writes/done during error",
        write_cnt - w0 + done_cnt - d0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err == 1'b0, "R1", "err cleared by reset", int'(err), 0);
  endtask

  initial begin
    busy_mode = 0; stall = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_holes();
    t_full();
    t_last_only();
    t_size2();
    t_error();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule